// File: doc/BRIEF.md
# Latched Parallel-to-Serial Shift Register

This block turns a parallel byte into a serial bit stream. A word is first captured from the parallel pins into a storage register when the storage strobe is pulsed. From there it is copied into a separate shift register whenever the load control is asserted. The shift register then moves its contents one place per shift strobe toward the serial output, taking a new bit from the serial input at the far end. Because the storage register is separate, the next word can be captured while the current word is still being shifted out.

Both strobes are single-cycle enables in one system clock domain, and reset is synchronous and active high. The serial output is given as a data bit plus an enable flag. A pad or a shared-line driver outside the block turns these into a tri-state driver, so that several devices can share one serial line.

Top module: `latched_piso`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) clears both the storage register and the shift register to all zeros. After reset, ser_data is 0, and a load with no capture beforehand shifts out only zeros.
- R2: When store_en is high at a clock edge, par_in is copied into the storage register. When store_en is low, the storage register keeps its value.
- R3: When load_n is low at a clock edge, the shift register is loaded in parallel from the storage register. This happens whatever the value of shift_en, so a load overrides a shift.
- R4: When load_n is high and shift_en is high, the shift register moves one place toward the output. Stage 0 takes ser_in, and each stage k takes the old value of stage k-1.
- R5: A word that has been loaded is sent most significant bit first. par_in bit WIDTH-1 appears on ser_data right after the load, and bit 0 appears after WIDTH-1 shifts.
- R6: When store_en and shift_en are both high in the same cycle, with load_n high, both actions take effect. The shift stream already under way is not disturbed, and the new word is in storage for the next load.
- R7: When store_en is high and load_n is low in the same cycle, the shift register loads the par_in value present in that cycle (flow-through), not the older stored word.
- R8: ser_data always equals the last shift-register stage (WIDTH-1). ser_oe is high exactly when out_en_n is low, and it changes in the same cycle as out_en_n.
- R9: out_en_n affects only ser_oe. It never changes the contents of either register.
- R10: When load_n is high and shift_en is low, the shift register holds its contents, whatever the value of ser_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| par_in | input | WIDTH | Parallel data to be captured |
| store_en | input | 1 | Storage capture strobe (one cycle) |
| shift_en | input | 1 | Shift strobe (one cycle) |
| load_n | input | 1 | Parallel load control, active low, overrides shifting |
| ser_in | input | 1 | Serial input into stage 0 |
| out_en_n | input | 1 | Serial output enable, active low |
| ser_data | output | 1 | Last shift stage value |
| ser_oe | output | 1 | High when the serial driver should be enabled |

## Verification
The hardest case to create from the ports is a capture that lands while a word is halfway through being shifted out. The serial stream must stay intact, and the newly captured word must only show up at the next load. The stimulus reaches this by loading one random word and then pulsing store_en with a different word part-way through the shifts. It checks the remaining bits against the first word and then loads again to read back the second word. Flow-through is reached the same way, by raising store_en and lowering load_n in one cycle with fresh pins. The test also drives a load and a shift together, idle cycles with ser_in toggling, and out_en_n toggling in the middle of a stream.

// File: rtl/latched_piso_pkg.sv
package latched_piso_pkg;

    localparam int DEF_WIDTH = 8;

    typedef enum logic [1:0] {
        SR_HOLD  = 2'd0,
        SR_SHIFT = 2'd1,
        SR_LOAD  = 2'd2
    } sr_op_t;

    typedef struct packed {
        logic store;
        logic shift;
        logic load_n;
    } strobe_t;

    // Load has priority over shift.
    function automatic sr_op_t decode_op(input strobe_t s);
        if (!s.load_n)
            return SR_LOAD;
        else if (s.shift)
            return SR_SHIFT;
        else
            return SR_HOLD;
    endfunction

endpackage

// File: rtl/lp_store_reg.sv
module lp_store_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (capture)
            q <= d;
    end

endmodule

// File: rtl/lp_shift_reg.sv
module lp_shift_reg
    import latched_piso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  sr_op_t           op,
    input  logic [WIDTH-1:0] load_val,
    input  logic             ser_in,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] shifted;

    assign shifted[0] = ser_in;
    for (genvar k = 1; k < WIDTH; k++) begin : g_stage
        assign shifted[k] = q[k-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            case (op)
                SR_LOAD:  q <= load_val;
                SR_SHIFT: q <= shifted;
                default:  q <= q;
            endcase
        end
    end

endmodule

// File: rtl/lp_out_stage.sv
module lp_out_stage #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] sr_q,
    input  logic             out_en_n,
    output logic             ser_data,
    output logic             ser_oe
);

    localparam int LAST = WIDTH - 1;

    assign ser_data = sr_q[LAST];
    assign ser_oe   = ~out_en_n;

endmodule

// File: rtl/latched_piso.sv
module latched_piso
    import latched_piso_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] par_in,
    input  logic             store_en,
    input  logic             shift_en,
    input  logic             load_n,
    input  logic             ser_in,
    input  logic             out_en_n,
    output logic             ser_data,
    output logic             ser_oe
);

    strobe_t          strobes;
    sr_op_t           op;
    logic [WIDTH-1:0] stor_q;
    logic [WIDTH-1:0] load_val;
    logic [WIDTH-1:0] sr_q;

    assign strobes = '{store: store_en, shift: shift_en, load_n: load_n};
    assign op      = decode_op(strobes);

    // Flow-through: a capture in the load cycle feeds the pins straight in.
    assign load_val = store_en ? par_in : stor_q;

    lp_store_reg #(.WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .capture (store_en),
        .d       (par_in),
        .q       (stor_q)
    );

    lp_shift_reg #(.WIDTH(WIDTH)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .load_val (load_val),
        .ser_in   (ser_in),
        .q        (sr_q)
    );

    lp_out_stage #(.WIDTH(WIDTH)) u_out (
        .sr_q     (sr_q),
        .out_en_n (out_en_n),
        .ser_data (ser_data),
        .ser_oe   (ser_oe)
    );

endmodule

// File: rtl/latched_piso_checker.sv
module latched_piso_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] par_in,
    input logic             store_en,
    input logic             shift_en,
    input logic             load_n,
    input logic             ser_in,
    input logic             out_en_n,
    input logic             ser_data,
    input logic             ser_oe,
    input logic [WIDTH-1:0] stor_q,
    input logic [WIDTH-1:0] sr_q
);

    a_r1_reset_clears: assert property (@(posedge clk)
        $past(rst) && !rst |-> (stor_q == '0) && (sr_q == '0));

    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        store_en |=> stor_q == $past(par_in));

    a_r2_keep: assert property (@(posedge clk) disable iff (rst)
        !store_en |=> $stable(stor_q));

    a_r3_load_from_store: assert property (@(posedge clk) disable iff (rst)
        !load_n && !store_en |=> sr_q == $past(stor_q));

    a_r4_shift_step: assert property (@(posedge clk) disable iff (rst)
        load_n && shift_en |=> sr_q == {$past(sr_q[WIDTH-2:0]), $past(ser_in)});

    a_r7_flow_through: assert property (@(posedge clk) disable iff (rst)
        !load_n && store_en |=> sr_q == $past(par_in));

    a_r8_out_last_stage: assert property (@(posedge clk) disable iff (rst)
        ser_data == sr_q[WIDTH-1]);

    a_r8_oe_follows: assert property (@(posedge clk) disable iff (rst)
        ser_oe != out_en_n);

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        load_n && !shift_en |=> $stable(sr_q));

endmodule

bind latched_piso latched_piso_checker #(.WIDTH(WIDTH)) u_checker (
    .clk      (clk),
    .rst      (rst),
    .par_in   (par_in),
    .store_en (store_en),
    .shift_en (shift_en),
    .load_n   (load_n),
    .ser_in   (ser_in),
    .out_en_n (out_en_n),
    .ser_data (ser_data),
    .ser_oe   (ser_oe),
    .stor_q   (stor_q),
    .sr_q     (sr_q)
);

// File: tb/test_latched_piso.sv
module test_latched_piso;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] par_in = '0;
    logic         store_en = 1'b0;
    logic         shift_en = 1'b0;
    logic         load_n = 1'b1;
    logic         ser_in = 1'b0;
    logic         out_en_n = 1'b1;
    logic         ser_data;
    logic         ser_oe;

    int n_cmp = 0;
    int n_bad = 0;
    logic [W-1:0] m_stor = '0;
    logic [W-1:0] m_sr = '0;

    always #4 clk = ~clk;

    latched_piso #(.WIDTH(W)) i_latched_piso (
        .clk(clk), .rst(rst), .par_in(par_in), .store_en(store_en),
        .shift_en(shift_en), .load_n(load_n), .ser_in(ser_in),
        .out_en_n(out_en_n), .ser_data(ser_data), .ser_oe(ser_oe)
    );

    function automatic logic [W-1:0] next_sr(input logic [W-1:0] sr,
        input logic [W-1:0] stor, input logic [W-1:0] pins,
        input logic st, input logic sh, input logic ld_n, input logic sin);
        if (!ld_n) return st ? pins : stor;
        if (sh)    return {sr[W-2:0], sin};
        return sr;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, sample 1 ns after the rising edge.
    task automatic cyc(input logic st, input logic sh, input logic ld_n,
                       input logic sin, input logic [W-1:0] pins,
                       input logic oe_n, input string req);
        @(negedge clk);
        store_en = st; shift_en = sh; load_n = ld_n; ser_in = sin;
        par_in = pins; out_en_n = oe_n;
        @(posedge clk);
        #1;
        if (!rst) begin
            m_sr   = next_sr(m_sr, m_stor, pins, st, sh, ld_n, sin);
            if (st) m_stor = pins;
        end
        check(req, ser_data, m_sr[W-1]);
        check("R8 oe", ser_oe, ~oe_n);
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0, "R10");
    endtask

    initial begin : watchdog
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [W-1:0] a, b;
        logic [W-1:0] sins;
        void'($urandom(32'h5eed_1234));

        // R1: drive junk during reset, then check the cleared state.
        rst = 1'b1;
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 8'hff, 1'b1, "R1");
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 8'hff, 1'b1, "R1");
        rst = 1'b0;
        m_sr = '0; m_stor = '0;
        check("R1 reset data", ser_data, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'ha5, 1'b0, "R1 load of cleared store");
        for (int i = 0; i < W; i++) begin
            check("R1 zero stream", ser_data, 1'b0);
            cyc(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R1");
        end

        // R2 R3 R4 R5: random words, MSB first, then ser_in bits follow.
        for (int t = 0; t < 24; t++) begin
            a = W'($urandom);
            sins = W'($urandom);
            cyc(1'b1, 1'b0, 1'b1, 1'b0, a, 1'b0, "R2 capture");
            cyc(1'b0, 1'b0, 1'b0, 1'b0, ~a, 1'b0, "R3 load");
            for (int i = 0; i < W; i++) begin
                check("R5 msb first", ser_data, a[W-1-i]);
                cyc(1'b0, 1'b1, 1'b1, sins[W-1-i], ~a, 1'(t & 1), "R4 shift");
            end
            for (int i = 0; i < W; i++) begin
                check("R4 ser_in stream", ser_data, sins[W-1-i]);
                cyc(1'b0, 1'b1, 1'b1, 1'b0, '0, 1'b0, "R4 shift");
            end
        end

        // R3: load overrides a simultaneous shift.
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'h3c, 1'b0, "R2");
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, "R3 override");
        check("R3 override msb", ser_data, 1'b0);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R4");
        check("R3 override bit6", ser_data, 1'b0);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R4");
        check("R3 override bit5", ser_data, 1'b1);

        // R6: capture during shifting leaves the stream intact.
        for (int t = 0; t < 8; t++) begin
            a = W'($urandom);
            b = W'($urandom);
            cyc(1'b1, 1'b0, 1'b0, 1'b0, a, 1'b0, "R7");
            for (int i = 0; i < W; i++) begin
                check("R6 stream kept", ser_data, a[W-1-i]);
                cyc((i == 3), 1'b1, 1'b1, 1'b0, (i == 3) ? b : ~b, 1'b0, "R6 shift+store");
            end
            cyc(1'b0, 1'b0, 1'b0, 1'b0, a, 1'b0, "R6 reload");
            for (int i = 0; i < W; i++) begin
                check("R6 new word", ser_data, b[W-1-i]);
                cyc(1'b0, 1'b1, 1'b1, 1'b0, a, 1'b0, "R4");
            end
        end

        // R7: flow-through load from fresh pins.
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'h0f, 1'b0, "R2");
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'hc3, 1'b0, "R7 flow");
        for (int i = 0; i < W; i++) begin
            check("R7 flow stream", ser_data, 8'hc3 >> (W-1-i));
            cyc(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R4");
        end

        // R9 and R10: enable toggling and idle cycles do not disturb contents.
        a = 8'hb6;
        cyc(1'b1, 1'b0, 1'b0, 1'b0, a, 1'b1, "R7");
        for (int i = 0; i < W; i++) begin
            cyc(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, "R9 oe on");
            cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, "R9 oe off");
            check("R10 hold", ser_data, a[W-1-i]);
            check("R9 oe no effect", ser_oe, 1'b0);
            cyc(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'(i & 1), "R4");
        end
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, "R9 store kept");
        for (int i = 0; i < W; i++) begin
            check("R9 store intact", ser_data, a[W-1-i]);
            cyc(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R4");
        end
        idle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule